// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block rewrites a linear byte address into the form seen by a two-channel interleaved memory when the address belongs to a tiled surface. Address bit 6 picks the channel. For tiled surfaces, the block replaces that bit with the XOR of bit 6 and a set of higher address bits. The set depends on two things: the tiling format (X or Y), and whether the memory controller mixes in extra randomization from bit 11 or bit 17. Every other address bit passes through unchanged. Linear surfaces are never altered.

A configuration stage derives one swizzle mode for X tiles and one for Y tiles. It is loaded on a strobe from one of two sources:

- In legacy form, the source is a controller configuration word that holds a channel mode field and two randomization controls.
- In the later form, the source is an equality comparison of the two channel size fields.

The block reports the active modes to the requester with bit 17 hidden. It also flags an "unknown" status, which forces tiled requests to pass unchanged. Each address request goes through one register stage, and a valid bit follows it.

Top module: `tile_swizzle_unit`

## Requirements
- R1: After reset, outValid is 0, modeX and modeY read 0 (no swizzle) and tileOff is 0.
- R2: A request with reqTile 0 (linear) or 3 (reserved, treated as linear) produces outAddr equal to reqAddr.
- R3: For reqTile 1 (X tiles), outAddr bit 6 is bit 6 XOR bit 9 XOR bit 10 of reqAddr in mode codes 2, 4 and 6. Every bit of outAddr other than bit 6 always equals the same bit of reqAddr.
- R4: For reqTile 2 (Y tiles), outAddr bit 6 is bit 6 XOR bit 9 of reqAddr in mode codes 1, 3 and 5.
- R5: In legacy configuration, the mode comes from ctrlWord. The channel mode field is ctrlWord[1:0], where 2 means interleaved. When ctrlWord[4] (randomization off) is set on an interleaved controller, the modes are X=2 (9/10) and Y=1 (9). When ctrlWord[4] and ctrlWord[5] are both clear, the modes are X=4 (9/10/11) and Y=3 (9/11), and address bit 11 is also XORed into bit 6.
- R6: In legacy configuration with ctrlWord[4] clear and ctrlWord[5] set, the internal modes are X=6 (9/10/17) and Y=5 (9/17), and address bit 17 is XORed into bit 6.
- R7: In legacy configuration, a channel mode field of 0 (single), 1 (asymmetric) or 3 gives mode 0 for both formats, and tiled addresses pass unchanged.
- R8: With cfgLegacy 0, both modes become X=2 and Y=1 when chanSizeA equals chanSizeB, and 0 otherwise.
- R9: In legacy configuration, a ctrlWord of all ones makes both modes 7 (unknown). The block then sets tileOff to 1 and passes tiled requests unchanged.
- R10: modeX and modeY never show bit 17. Internal mode 5 reads as 1, and internal mode 6 reads as 2.
- R11: outValid equals reqValid delayed by one clock. outAddr changes only in the cycle after a valid request.
- R12: Configuration takes effect at the clock edge where cfgLoad is high. A request presented in that same cycle is transformed with the configuration that was in force before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Strobe that captures a new configuration |
| cfgLegacy | input | 1 | 1: derive modes from ctrlWord; 0: derive them from the size comparison |
| ctrlWord | input | CW (32) | Controller configuration word: [1:0] channel mode, [4] randomization off, [5] bit-17 select |
| chanSizeA | input | SZ_W (8) | Size field of channel A |
| chanSizeB | input | SZ_W (8) | Size field of channel B |
| reqValid | input | 1 | Address request valid |
| reqTile | input | 2 | Tiling format: 0 linear, 1 X, 2 Y, 3 linear |
| reqAddr | input | AW (32) | Linear byte address |
| outValid | output | 1 | Transformed address valid |
| outAddr | output | AW (32) | Channel-swizzled address |
| modeX | output | 3 | Reported X-tile mode, with bit 17 hidden |
| modeY | output | 3 | Reported Y-tile mode, with bit 17 hidden |
| tileOff | output | 1 | Modes are unknown; tiling is forced to linear |

## Verification
A configuration load and an address request can land in the same cycle. The question is which mode the request uses.

The bench provokes this collision directly:

1. It first installs a configuration with no swizzle.
2. In a single cycle, it raises cfgLoad with an interleaved configuration and also presents an X-tile address with bits 9 and 10 chosen so that bit 6 would flip.
3. It checks that the returned address is unchanged, which shows the old mode was applied.
4. It checks that the mode ports already show the new modes.
5. It sends a follow-up request with the same address and expects the flipped bit.

// File: rtl/tswz_pkg.sv
package tswz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swzMode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tileFmt_e;

  // control-to-datapath strobes: the active internal mode per format
  typedef struct packed {
    swzMode_e xMode;
    swzMode_e yMode;
  } swzCtl_t;

  // controller word field positions
  localparam int CHMODE_LSB    = 0;
  localparam int XOR_OFF_POS   = 4;
  localparam int HIGH_SEL_POS  = 5;
  localparam logic [1:0] CHMODE_INTERLEAVED = 2'd2;

  // bit positions that feed the channel bit
  localparam int CH_BIT   = 6;
  localparam int TX_BIT_A = 9;
  localparam int TX_BIT_B = 10;
  localparam int RND_LO   = 11;
  localparam int RND_HI   = 17;

  function automatic swzMode_e hideHigh(swzMode_e m);
    case (m)
      SWZ_9_17:    return SWZ_9;
      SWZ_9_10_17: return SWZ_9_10;
      default:     return m;
    endcase
  endfunction

endpackage

// File: rtl/tswz_mode_ctrl.sv
module tswz_mode_ctrl
  import tswz_pkg::*;
#(
  parameter int CW   = 32,
  parameter int SZ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgLoad,
  input  logic            cfgLegacy,
  input  logic [CW-1:0]   ctrlWord,
  input  logic [SZ_W-1:0] chanSizeA,
  input  logic [SZ_W-1:0] chanSizeB,
  output swzCtl_t         ctl
);

  swzCtl_t nextCtl;
  logic    wordBad;
  logic [1:0] chMode;

  assign wordBad = &ctrlWord;
  assign chMode  = ctrlWord[CHMODE_LSB +: 2];

  always_comb begin
    nextCtl.xMode = SWZ_NONE;
    nextCtl.yMode = SWZ_NONE;
    if (!cfgLegacy) begin
      if (chanSizeA == chanSizeB) begin
        nextCtl.xMode = SWZ_9_10;
        nextCtl.yMode = SWZ_9;
      end
    end else if (wordBad) begin
      nextCtl.xMode = SWZ_UNKNOWN;
      nextCtl.yMode = SWZ_UNKNOWN;
    end else if (chMode == CHMODE_INTERLEAVED) begin
      if (ctrlWord[XOR_OFF_POS]) begin
        nextCtl.xMode = SWZ_9_10;
        nextCtl.yMode = SWZ_9;
      end else if (!ctrlWord[HIGH_SEL_POS]) begin
        nextCtl.xMode = SWZ_9_10_11;
        nextCtl.yMode = SWZ_9_11;
      end else begin
        nextCtl.xMode = SWZ_9_10_17;
        nextCtl.yMode = SWZ_9_17;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl.xMode <= SWZ_NONE;
      ctl.yMode <= SWZ_NONE;
    end else if (cfgLoad) begin
      ctl <= nextCtl;
    end
  end

  // R12: modes change only on a load strobe
  assert_cfg_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgLoad |=> $stable(ctl));

  // R9: an all-ones legacy word leaves both formats unknown
  assert_unknown_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad && cfgLegacy && (&ctrlWord)) |=>
      (ctl.xMode == SWZ_UNKNOWN && ctl.yMode == SWZ_UNKNOWN));

  // R8: later form never produces randomized or unknown modes
  assert_later_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad && !cfgLegacy) |=>
      ((ctl.xMode == SWZ_NONE || ctl.xMode == SWZ_9_10) &&
       (ctl.yMode == SWZ_NONE || ctl.yMode == SWZ_9)));

endmodule

// File: rtl/tswz_addr_path.sv
module tswz_addr_path
  import tswz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  swzCtl_t       ctl,
  input  logic          reqValid,
  input  logic [1:0]    reqTile,
  input  logic [AW-1:0] reqAddr,
  output logic          outValid,
  output logic [AW-1:0] outAddr
);

  localparam logic [AW-1:0] CH_MASK = AW'(1) << CH_BIT;

  swzMode_e   selMode;
  logic       flip;
  logic [AW-1:0] swzAddr;

  always_comb begin
    case (tileFmt_e'(reqTile))
      TILE_X:  selMode = ctl.xMode;
      TILE_Y:  selMode = ctl.yMode;
      default: selMode = SWZ_NONE;
    endcase
  end

  always_comb begin
    case (selMode)
      SWZ_9:       flip = reqAddr[TX_BIT_A];
      SWZ_9_10:    flip = reqAddr[TX_BIT_A] ^ reqAddr[TX_BIT_B];
      SWZ_9_11:    flip = reqAddr[TX_BIT_A] ^ reqAddr[RND_LO];
      SWZ_9_10_11: flip = reqAddr[TX_BIT_A] ^ reqAddr[TX_BIT_B] ^ reqAddr[RND_LO];
      SWZ_9_17:    flip = reqAddr[TX_BIT_A] ^ reqAddr[RND_HI];
      SWZ_9_10_17: flip = reqAddr[TX_BIT_A] ^ reqAddr[TX_BIT_B] ^ reqAddr[RND_HI];
      default:     flip = 1'b0;
    endcase
    swzAddr = reqAddr;
    swzAddr[CH_BIT] = reqAddr[CH_BIT] ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outAddr  <= '0;
    end else begin
      outValid <= reqValid;
      if (reqValid) outAddr <= swzAddr;
    end
  end

  // R11: valid follows the request by one cycle, address held when idle
  assert_valid_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!outValid && $stable(outAddr)));

  // R3: only the channel bit may differ from the request
  assert_upper_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> ((outAddr & ~CH_MASK) == ($past(reqAddr) & ~CH_MASK)));

  // R2: linear requests are untouched
  assert_linear_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (reqTile == TILE_LINEAR || reqTile == TILE_RSVD)) |=>
      (outAddr == $past(reqAddr)));

endmodule

// File: rtl/tile_swizzle_unit.sv
module tile_swizzle_unit
  import tswz_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int SZ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgLoad,
  input  logic            cfgLegacy,
  input  logic [CW-1:0]   ctrlWord,
  input  logic [SZ_W-1:0] chanSizeA,
  input  logic [SZ_W-1:0] chanSizeB,
  input  logic            reqValid,
  input  logic [1:0]      reqTile,
  input  logic [AW-1:0]   reqAddr,
  output logic            outValid,
  output logic [AW-1:0]   outAddr,
  output logic [2:0]      modeX,
  output logic [2:0]      modeY,
  output logic            tileOff
);

  swzCtl_t ctl;

  tswz_mode_ctrl #(.CW(CW), .SZ_W(SZ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad), .cfgLegacy(cfgLegacy),
    .ctrlWord(ctrlWord), .chanSizeA(chanSizeA), .chanSizeB(chanSizeB),
    .ctl(ctl)
  );

  tswz_addr_path #(.AW(AW)) u_path (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqValid(reqValid),
    .reqTile(reqTile), .reqAddr(reqAddr),
    .outValid(outValid), .outAddr(outAddr)
  );

  assign modeX   = hideHigh(ctl.xMode);
  assign modeY   = hideHigh(ctl.yMode);
  assign tileOff = (ctl.xMode == SWZ_UNKNOWN);

  // R10: reported modes never carry bit 17
  assert_hidden_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeX != 3'd5 && modeX != 3'd6 && modeY != 3'd5 && modeY != 3'd6));

endmodule

// File: tb/tile_swizzle_unit_tb.sv
module tile_swizzle_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgLoad = 1'b0;
  logic        cfgLegacy = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [7:0]  chanSizeA = '0;
  logic [7:0]  chanSizeB = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqTile = '0;
  logic [31:0] reqAddr = '0;
  logic        outValid;
  logic [31:0] outAddr;
  logic [2:0]  modeX, modeY;
  logic        tileOff;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tile_swizzle_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad), .cfgLegacy(cfgLegacy),
    .ctrlWord(ctrlWord), .chanSizeA(chanSizeA), .chanSizeB(chanSizeB),
    .reqValid(reqValid), .reqTile(reqTile), .reqAddr(reqAddr),
    .outValid(outValid), .outAddr(outAddr), .modeX(modeX), .modeY(modeY),
    .tileOff(tileOff)
  );

  typedef struct packed {
    logic        legacy;
    logic [31:0] word;
    logic [7:0]  sA;
    logic [7:0]  sB;
    logic [31:0] addr;
    logic [2:0]  expX;
    logic [2:0]  expY;
    logic        expOff;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0012, 8'd0, 8'd0, 32'h0000_0600, 3'd2, 3'd1, 1'b0}, // R5 xor off
    '{1'b1, 32'h0000_0002, 8'd0, 8'd0, 32'h0000_0A40, 3'd4, 3'd3, 1'b0}, // R5 bit 11
    '{1'b1, 32'h0000_0022, 8'd0, 8'd0, 32'h0002_0200, 3'd2, 3'd1, 1'b0}, // R6 R10 bit 17
    '{1'b1, 32'h0000_0000, 8'd0, 8'd0, 32'h0002_0E00, 3'd0, 3'd0, 1'b0}, // R7 single
    '{1'b1, 32'h0000_0001, 8'd0, 8'd0, 32'h0000_0E40, 3'd0, 3'd0, 1'b0}, // R7 asym
    '{1'b1, 32'h0000_0003, 8'd0, 8'd0, 32'h0000_0200, 3'd0, 3'd0, 1'b0}, // R7 reserved
    '{1'b1, 32'hFFFF_FFFF, 8'd0, 8'd0, 32'h0002_0E00, 3'd7, 3'd7, 1'b1}, // R9 unknown
    '{1'b0, 32'h0000_0000, 8'h40, 8'h40, 32'h0000_0440, 3'd2, 3'd1, 1'b0}, // R8 equal
    '{1'b0, 32'h0000_0002, 8'h40, 8'h20, 32'h0000_0600, 3'd0, 3'd0, 1'b0}  // R8 unequal
  };

  // bench model of the internal mode
  function automatic logic [2:0] mdlMode(logic leg, logic [31:0] w,
                                         logic [7:0] a, logic [7:0] b, logic isY);
    if (!leg) return (a == b) ? (isY ? 3'd1 : 3'd2) : 3'd0;
    if (w == 32'hFFFF_FFFF) return 3'd7;
    if (w[1:0] != 2'd2) return 3'd0;
    if (w[4]) return isY ? 3'd1 : 3'd2;
    if (!w[5]) return isY ? 3'd3 : 3'd4;
    return isY ? 3'd5 : 3'd6;
  endfunction

  function automatic logic [31:0] mdlAddr(logic [2:0] m, logic [31:0] a);
    logic f;
    logic [31:0] r;
    r = a;
    if (m == 3'd0 || m == 3'd7) return r;
    f = a[9];
    if (m == 3'd2 || m == 3'd4 || m == 3'd6) f = f ^ a[10];
    if (m == 3'd3 || m == 3'd4) f = f ^ a[11];
    if (m == 3'd5 || m == 3'd6) f = f ^ a[17];
    r[6] = r[6] ^ f;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadCfg(logic leg, logic [31:0] w, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    cfgLoad = 1'b1; cfgLegacy = leg; ctrlWord = w; chanSizeA = a; chanSizeB = b;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic sendReq(logic [1:0] t, logic [31:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqTile = t; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    checks++; errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outValid", {31'd0, outValid}, 32'd0);
    chk("R1 modeX", {29'd0, modeX}, 32'd0);
    chk("R1 modeY", {29'd0, modeY}, 32'd0);
    chk("R1 tileOff", {31'd0, tileOff}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [2:0] mx, my;
      v = VECS[i];
      loadCfg(v.legacy, v.word, v.sA, v.sB);
      chk("R5-R9 modeX (R10)", {29'd0, modeX}, {29'd0, v.expX});
      chk("R5-R9 modeY (R10)", {29'd0, modeY}, {29'd0, v.expY});
      chk("R9 tileOff", {31'd0, tileOff}, {31'd0, v.expOff});
      mx = mdlMode(v.legacy, v.word, v.sA, v.sB, 1'b0);
      my = mdlMode(v.legacy, v.word, v.sA, v.sB, 1'b1);
      sendReq(2'd1, v.addr);
      chk("R3 X addr", outAddr, mdlAddr(mx, v.addr));
      chk("R11 outValid", {31'd0, outValid}, 32'd1);
      sendReq(2'd2, v.addr);
      chk("R4 Y addr", outAddr, mdlAddr(my, v.addr));
      sendReq(2'd0, v.addr ^ 32'h0000_0040);
      chk("R2 linear addr", outAddr, v.addr ^ 32'h0000_0040);
    end

    // R2 reserved tile code under an active swizzle
    loadCfg(1'b1, 32'h0000_0012, 8'd0, 8'd0);
    sendReq(2'd3, 32'h0000_0200);
    chk("R2 reserved tile", outAddr, 32'h0000_0200);

    // R6 bit 17 alone drives the flip for Y (9/17)
    loadCfg(1'b1, 32'h0000_0022, 8'd0, 8'd0);
    sendReq(2'd2, 32'h0002_0000);
    chk("R6 Y bit17", outAddr, 32'h0002_0040);

    // R11 idle cycle: valid drops, address holds
    @(negedge clk);
    chk("R11 idle valid", {31'd0, outValid}, 32'd0);
    chk("R11 idle hold", outAddr, 32'h0002_0040);

    // R12 collision: load and request in the same cycle
    loadCfg(1'b0, 32'd0, 8'h10, 8'h20);
    @(negedge clk);
    cfgLoad = 1'b1; cfgLegacy = 1'b0; chanSizeA = 8'h30; chanSizeB = 8'h30;
    reqValid = 1'b1; reqTile = 2'd1; reqAddr = 32'h0000_0200;
    @(negedge clk);
    cfgLoad = 1'b0; reqValid = 1'b0;
    chk("R12 old mode used", outAddr, 32'h0000_0200);
    chk("R12 new modeX", {29'd0, modeX}, 32'd2);
    sendReq(2'd1, 32'h0000_0200);
    chk("R12 new mode used", outAddr, 32'h0000_0240);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule